// File: doc/BRIEF.md
# Two-Wire ADC Readout Slave

This block is the serial front end of a 16-bit sampling converter on a two-wire open-drain bus. It watches the synchronized clock and data lines for START, repeated START and STOP conditions. It compares the first byte of each transaction against its own 7-bit device address. When the address matches, it acknowledges the byte, powers the converter up and starts a conversion. It holds the clock line low until the converter signals completion, then sends the result as two bytes, most significant byte first.

The master reads the device by acknowledging. Each acknowledge after a low byte starts another conversion, and the new result is sent the same way with no new address phase. A not-acknowledge ends the stream and frees both lines. In this device the direction bit of the address byte does not choose between read and write. In internal-reference mode it decides whether the reference stays on or is armed for shutdown.

A first byte of the high-speed master-code form switches the block into a high-speed mode flag, which stays set until a STOP. The converter is outside this block and is reached through a start pulse, a done strobe and a result bus. A timeout counter flags a converter that never answers.

Top module: `adc_twowire_slave`

## Requirements
- R1: After reset, both line pulls, conv_start, pwr_up, ref_off, hs_mode and timeout_err are all low.
- R2: The first byte after a START is seven address bits followed by one direction bit, most significant bit first. When the address equals DEV_ADDR, the block pulls SDA low during the ninth clock.
- R3: A non-matching address is not acknowledged. All later bytes are ignored until the next START, even a byte that carries the matching address.
- R4: At the falling SCL edge that ends the address acknowledge, the block issues a one-cycle conv_start and pulls SCL low. SCL stays pulled until conv_done.
- R5: The 16-bit result is sent with bits 15..8 first and bits 7..0 second, each byte most significant bit first. SDA is pulled low for a 0 bit and released for a 1 bit.
- R6: A master acknowledge (SDA low in the ninth clock) after the low byte starts a new conversion, with SCL held again. That result is then streamed without a new address byte.
- R7: A master not-acknowledge after either byte releases SDA and SCL. No further conversion is started until a new START.
- R8: pwr_up rises when a matching address is accepted, and again for each streamed conversion. It falls on every conv_done and on a timeout.
- R9: When int_ref_i is 1, an accepted address sets ref_off to the inverse of the direction bit. When int_ref_i is 0, the direction bit leaves ref_off unchanged.
- R10: A first byte whose upper five bits are 00001 is not acknowledged and sets hs_mode. hs_mode survives a repeated START and is cleared by a STOP.
- R11: If conv_done does not arrive within TIMEOUT_CYC cycles of conv_start, timeout_err rises, and SCL and pwr_up are released. timeout_err is cleared by the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| scl_pull | output | 1 | 1 pulls the clock line low (clock stretch) |
| sda_pull | output | 1 | 1 pulls the data line low |
| int_ref_i | input | 1 | 1 selects internal-reference mode |
| conv_start | output | 1 | One-cycle conversion request to the converter |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_data | input | DATA_W | Conversion result, valid with conv_done |
| pwr_up | output | 1 | Converter power enable |
| ref_off | output | 1 | Reference shutdown armed |
| hs_mode | output | 1 | High-speed mode flag |
| timeout_err | output | 1 | Converter failed to answer in time |

## Verification
Two situations are the hardest to reach from the ports. The first is the acknowledge after a low byte, which must restart a conversion with no address phase. The second is the timeout, which only fires when the converter stays silent. The bench's converter model can be switched off to reach the timeout. The bench then reads three back-to-back conversions to cover the streaming acknowledge. A sweep of all 128 address values, with the direction bit set, exercises both the match and the master-code decode. Every expected byte comes from a closed-form sequence indexed by the conversion count.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int ADDR_W = 7;
  localparam logic [4:0] HS_PREFIX = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CONV,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } link_state_t;
endpackage

// File: rtl/tws_bus_sync.sv
module tws_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tws_conv_timer.sv
module tws_conv_timer #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en  = run & (cnt_q != LIMIT);
  assign expired = run & (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tws_link_fsm.sv
module tws_link_fsm
  import tws_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h34,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              int_ref_i,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              tmo_expired,
  output logic              in_conv,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              conv_start,
  output logic              pwr_up,
  output logic              ref_off,
  output logic              hs_mode,
  output logic              timeout_err
);
  localparam int NBYTES = DATA_W / 8;
  localparam int BW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BW-1:0] LAST_BYTE = BW'(NBYTES - 1);

  link_state_t       st_q, st_d;
  logic [3:0]        bit_q, bit_d;
  logic [7:0]        rx_q, rx_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [BW-1:0]     byte_q, byte_d;
  logic              nack_q, nack_d;
  logic              sda_q, sda_d;
  logic              scl_q, scl_d;
  logic              cs_q, cs_d;
  logic              pwr_q, pwr_d;
  logic              ref_q, ref_d;
  logic              hs_q, hs_d;
  logic              err_q, err_d;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    byte_d = byte_q;
    nack_d = nack_q;
    sda_d  = sda_q;
    scl_d  = scl_q;
    cs_d   = 1'b0;
    pwr_d  = pwr_q;
    ref_d  = ref_q;
    hs_d   = hs_q;
    err_d  = err_q;

    if (conv_done) pwr_d = 1'b0;

    if (stop_det) begin
      st_d  = ST_IDLE;
      sda_d = 1'b0;
      scl_d = 1'b0;
      hs_d  = 1'b0;
    end else if (start_det) begin
      st_d  = ST_ADDR;
      bit_d = '0;
      sda_d = 1'b0;
      scl_d = 1'b0;
      err_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise && bit_q != 4'd8) begin
            rx_d  = {rx_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (rx_q[7:1] == DEV_ADDR) begin
              st_d  = ST_ADDR_ACK;
              sda_d = 1'b1;
              pwr_d = 1'b1;
              if (int_ref_i) ref_d = ~rx_q[0];
            end else begin
              st_d = ST_WAIT;
              if (rx_q[7:3] == HS_PREFIX) hs_d = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            st_d  = ST_CONV;
            sda_d = 1'b0;
            scl_d = 1'b1;
            cs_d  = 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            st_d   = ST_TX;
            tx_d   = conv_data;
            sda_d  = ~conv_data[DATA_W-1];
            scl_d  = 1'b0;
            bit_d  = '0;
            byte_d = '0;
          end else if (tmo_expired) begin
            st_d  = ST_WAIT;
            scl_d = 1'b0;
            pwr_d = 1'b0;
            err_d = 1'b1;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              st_d  = ST_MACK;
              sda_d = 1'b0;
              bit_d = '0;
            end else begin
              bit_d = bit_q + 4'd1;
              tx_d  = {tx_q[DATA_W-2:0], 1'b0};
              sda_d = ~tx_q[DATA_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_d = ST_WAIT;
            end else if (byte_q != LAST_BYTE) begin
              st_d   = ST_TX;
              byte_d = byte_q + 1'b1;
              tx_d   = {tx_q[DATA_W-2:0], 1'b0};
              sda_d  = ~tx_q[DATA_W-2];
              bit_d  = '0;
            end else begin
              st_d  = ST_CONV;
              scl_d = 1'b1;
              cs_d  = 1'b1;
              pwr_d = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      byte_q <= '0;
      nack_q <= 1'b0;
      sda_q  <= 1'b0;
      scl_q  <= 1'b0;
      cs_q   <= 1'b0;
      pwr_q  <= 1'b0;
      ref_q  <= 1'b0;
      hs_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      byte_q <= byte_d;
      nack_q <= nack_d;
      sda_q  <= sda_d;
      scl_q  <= scl_d;
      cs_q   <= cs_d;
      pwr_q  <= pwr_d;
      ref_q  <= ref_d;
      hs_q   <= hs_d;
      err_q  <= err_d;
    end
  end

  assign in_conv     = (st_q == ST_CONV);
  assign scl_pull    = scl_q;
  assign sda_pull    = sda_q;
  assign conv_start  = cs_q;
  assign pwr_up      = pwr_q;
  assign ref_off     = ref_q;
  assign hs_mode     = hs_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/adc_twowire_slave.sv
module adc_twowire_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h34,
  parameter int         DATA_W      = 16,
  parameter int         TIMEOUT_CYC = 4096,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              int_ref_i,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              pwr_up,
  output logic              ref_off,
  output logic              hs_mode,
  output logic              timeout_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic       in_conv;
  logic       tmo_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tws_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tws_conv_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (in_conv),
    .expired (tmo_expired)
  );

  tws_link_fsm #(.DEV_ADDR(DEV_ADDR), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .int_ref_i   (int_ref_i),
    .conv_done   (conv_done),
    .conv_data   (conv_data),
    .tmo_expired (tmo_expired),
    .in_conv     (in_conv),
    .scl_pull    (scl_pull),
    .sda_pull    (sda_pull),
    .conv_start  (conv_start),
    .pwr_up      (pwr_up),
    .ref_off     (ref_off),
    .hs_mode     (hs_mode),
    .timeout_err (timeout_err)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic conv_done,
  input logic scl_pull,
  input logic pwr_up,
  input logic ref_off,
  input logic hs_mode,
  input logic int_ref_i,
  input logic timeout_err,
  input logic stop_det
);
  AST_START_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R4

  AST_STRETCH_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> scl_pull); // R4

  AST_POWER_DOWN_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !pwr_up); // R8

  AST_EXT_REF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ref_i |=> $stable(ref_off)); // R9

  AST_STOP_CLEARS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode); // R10

  AST_ERR_RELEASES_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !scl_pull); // R11
endmodule

bind adc_twowire_slave tws_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .conv_start  (conv_start),
  .conv_done   (conv_done),
  .scl_pull    (scl_pull),
  .pwr_up      (pwr_up),
  .ref_off     (ref_off),
  .hs_mode     (hs_mode),
  .int_ref_i   (int_ref_i),
  .timeout_err (timeout_err),
  .stop_det    (stop_det)
);

// File: tb/adc_twowire_slave_test.sv
`timescale 1ns/1ps
module adc_twowire_slave_test;
  localparam logic [6:0] DEV = 7'h34;
  localparam int TMO  = 200;
  localparam int LAT  = 40;
  localparam int HALF = 10;

  logic clk;
  logic rst_n;
  logic m_scl_low, m_sda_low;
  logic scl_pull, sda_pull;
  logic int_ref;
  logic conv_start, conv_done;
  logic [15:0] conv_data;
  logic pwr_up, ref_off, hs_mode, timeout_err;
  logic scl_line, sda_line;
  logic conv_en;
  int   conv_idx, starts, n_chk, n_fail, nk;

  assign scl_line = ~(m_scl_low | scl_pull);
  assign sda_line = ~(m_sda_low | sda_pull);

  adc_twowire_slave #(.DEV_ADDR(DEV), .DATA_W(16), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .int_ref_i(int_ref),
    .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
    .pwr_up(pwr_up), .ref_off(ref_off), .hs_mode(hs_mode), .timeout_err(timeout_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] exp_val(int k);
    return 16'hB3D1 ^ 16'(k * 16'h2F47);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // converter model
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    conv_idx  = 0;
    starts    = 0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        starts++;
        if (conv_en) begin
          repeat (LAT) @(negedge clk);
          conv_data = exp_val(conv_idx);
          conv_done = 1'b1;
          @(negedge clk);
          conv_done = 1'b0;
          conv_idx++;
        end
      end
    end
  end

  task automatic wait_scl_high(output int hold);
    hold = 0;
    tick(1);
    while (!scl_line) begin
      hold++;
      tick(1);
    end
  endtask

  task automatic clk_bit(output logic b, output int hold);
    m_scl_low = 1'b0;
    wait_scl_high(hold);
    tick(HALF);
    b = sda_line;
    m_scl_low = 1'b1;
    tick(HALF);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick(HALF);
    m_scl_low = 1'b0; tick(HALF);
    m_sda_low = 1'b1; tick(HALF);
    m_scl_low = 1'b1; tick(HALF);
  endtask

  task automatic bus_stop();
    int h;
    m_sda_low = 1'b1; tick(HALF);
    m_scl_low = 1'b0;
    wait_scl_high(h);
    tick(HALF);
    m_sda_low = 1'b0; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    int h;
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i];
      clk_bit(s, h);
    end
    m_sda_low = 1'b0;
    clk_bit(s, h);
    acked = ~s;
  endtask

  task automatic read_byte(input logic ack, output logic [7:0] b, output int hold);
    logic s;
    int h;
    m_sda_low = 1'b0;
    hold = 0;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(s, h);
      b[i] = s;
      if (i == 7) hold = h;
    end
    m_sda_low = ack;
    clk_bit(s, h);
    m_sda_low = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] hi, lo;
    int hold, s0;
    n_chk = 0; n_fail = 0; nk = 0;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    int_ref = 1'b1; conv_en = 1'b1;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // R1 reset state
    check("R1", "outputs", {scl_pull, sda_pull, conv_start, pwr_up, ref_off, hs_mode, timeout_err}, 0);

    // R2 R3 R10 address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b1}, ack);
      check(a == int'(DEV) ? "R2" : "R3", $sformatf("ack addr %0h", a), int'(ack), int'(a == int'(DEV)));
      check("R10", $sformatf("hs after %0h", a), int'(hs_mode), int'(a >= 4 && a <= 7));
      if (ack) begin
        read_byte(1'b1, hi, hold);
        read_byte(1'b0, lo, hold);
        check("R5", "sweep data", int'({hi, lo}), int'(exp_val(nk)));
        nk++;
      end
      bus_stop();
      check("R10", "hs after stop", int'(hs_mode), 0);
    end
    check("R3", "conversions in sweep", starts, 1);

    // R4 R8 stretch and power; R5 R6 streaming
    s0 = starts;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check("R2", "ack", int'(ack), 1);
    check("R4", "scl stretched", int'(scl_pull), 1);
    check("R8", "powered during conv", int'(pwr_up), 1);
    for (int c = 0; c < 3; c++) begin
      read_byte(1'b1, hi, hold);
      if (c == 0) check("R4", "stretch long", int'(hold > LAT / 2), 1);
      check("R8", "powered down after done", int'(pwr_up), 0);
      read_byte(c < 2, lo, hold);
      check("R5", "high byte", int'(hi), int'(exp_val(nk) >> 8));
      check("R6", $sformatf("stream word %0d", c), int'({hi, lo}), int'(exp_val(nk)));
      nk++;
    end
    check("R6", "conversions in stream", starts - s0, 3);
    tick(20);
    check("R7", "lines released after nack", int'({scl_pull, sda_pull}), 0);
    bus_stop();

    // R7 nack after high byte
    s0 = starts;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    read_byte(1'b0, hi, hold);
    check("R5", "high byte only", int'(hi), int'(exp_val(nk) >> 8));
    nk++;
    read_byte(1'b1, lo, hold);
    check("R7", "bus free after nack", int'(lo), 8'hFF);
    check("R7", "no new conversion", starts - s0, 1);
    bus_stop();

    // R3 ignore until START
    s0 = starts;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b1}, ack);
    check("R3", "nonmatch ack", int'(ack), 0);
    send_byte({DEV, 1'b1}, ack);
    check("R3", "ignored later match", int'(ack), 0);
    check("R3", "no conversion", starts - s0, 0);
    bus_stop();

    // R9 reference control
    int_ref = 1'b1;
    bus_start(); send_byte({DEV, 1'b0}, ack);
    check("R9", "int ref dir0", int'(ref_off), 1);
    read_byte(1'b0, hi, hold); nk++; bus_stop();
    int_ref = 1'b0;
    bus_start(); send_byte({DEV, 1'b1}, ack);
    check("R9", "ext ref dir1 keeps", int'(ref_off), 1);
    read_byte(1'b0, hi, hold); nk++; bus_stop();
    int_ref = 1'b1;
    bus_start(); send_byte({DEV, 1'b1}, ack);
    check("R9", "int ref dir1", int'(ref_off), 0);
    read_byte(1'b0, hi, hold); nk++; bus_stop();
    int_ref = 1'b0;
    bus_start(); send_byte({DEV, 1'b0}, ack);
    check("R9", "ext ref dir0 keeps", int'(ref_off), 0);
    read_byte(1'b0, hi, hold); nk++; bus_stop();
    int_ref = 1'b1;

    // R10 high-speed entry via master code and repeated START
    bus_start();
    send_byte(8'h0B, ack);
    check("R10", "master code nack", int'(ack), 0);
    check("R10", "hs set", int'(hs_mode), 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check("R10", "ack in hs", int'(ack), 1);
    read_byte(1'b1, hi, hold);
    read_byte(1'b0, lo, hold);
    check("R6", "hs data", int'({hi, lo}), int'(exp_val(nk)));
    nk++;
    check("R10", "hs kept", int'(hs_mode), 1);
    bus_stop();
    check("R10", "hs cleared", int'(hs_mode), 0);

    // R11 timeout
    conv_en = 1'b0;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    tick(TMO + 40);
    check("R11", "error flag", int'(timeout_err), 1);
    check("R11", "scl released", int'(scl_pull), 0);
    check("R11", "powered down", int'(pwr_up), 0);
    bus_stop();
    conv_en = 1'b1;
    bus_start();
    check("R11", "cleared by start", int'(timeout_err), 0);
    send_byte({DEV, 1'b1}, ack);
    read_byte(1'b1, hi, hold);
    read_byte(1'b0, lo, hold);
    check("R11", "recovers", int'({hi, lo}), int'(exp_val(nk)));
    nk++;
    bus_stop();

    finish_run();
  end
endmodule